// File: doc/BRIEF.md
# Interval Timer with Prescaler and Auto-Reload

This block is a 32-bit down-counting interval timer that a processor reaches through a small word-addressed register window. Software programs a start count, a reload period and a clock divider. It then sets the power and run bits in the control word. While both bits are set, the count drops by one on every divider tick. When the count reaches zero, the timer raises a single-cycle interrupt request and latches a sticky flag in the control word.

In one-shot mode the count parks at zero after expiry and stays quiet. In reload mode it reloads from the period register on the same edge and keeps running. If the timer is switched on while the count already holds zero, it expires at once. Each switch-on after a full switch-off does this again. Turning power off freezes the count and keeps every register, so a later switch-on resumes from the held value.

Top module: `interval_timer`

## Requirements
- R1: After reset, all four registers read zero and `irq` is low.
- R2: The register window decodes only word-aligned offsets: 0x0 is control, 0x4 is period, 0x8 is prescale and 0xC is count. Period, prescale and count read back the last value written, whether the timer is running or powered off. Control reads only its low four bits, and the upper bits read zero. Writes to offsets with nonzero bits [1:0] are ignored, and reads at those offsets return zero.
- R3: The count changes only while control bit 0 (power) and bit 1 (run) are both 1. It then drops by one every (prescale + 1) clock cycles, and the first drop comes prescale + 1 cycles after the run starts.
- R4: If count N (N ≥ 1) and prescale P are loaded and a control write sets power and run at edge E, `irq` is high for exactly the one cycle that follows edge E + N·(P+1).
- R5: Control bit 3 is set by every expiry. A control write with bit 3 = 0 clears it, and writing bit 3 = 1 never sets it. After an expiry, control reads 0xB in one-shot mode and 0xF in reload mode.
- R6: When control bit 2 is 0, the count holds at zero after expiry and no further `irq` is raised.
- R7: When control bit 2 is 1, expiry loads the period value on the same edge that raises `irq`. The next `irq` follows period·(P+1) edges later.
- R8: When power and run become set together while the count is zero, `irq` is high in the cycle after the next edge. Every later switch-off and switch-on repeats this.
- R9: A count write takes effect on its edge, even while the timer runs, and no expiry is taken on that edge. Counting then continues from the written value.
- R10: Clearing power stops the divider and freezes the count. All registers keep their contents, and a later switch-on counts down from the frozen value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte offset into the register window |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr` (combinational) |
| irq | output | 1 | One-cycle interrupt request on expiry |

## Verification
The embedded properties assume that reset is held low across at least one rising edge before any access. They also assume that `bus_wr` and `bus_addr` are stable levels around each rising edge, so every write lands in exactly one cycle. The stimulus meets both assumptions: it drives all inputs on falling edges and keeps each strobe high for a single edge. It also uses only the four aligned offsets plus one misaligned probe. Counts, periods and prescale values stay small, so each sweep point finishes well within its wait limit, and every expected expiry edge is worked out as a product of count and prescale.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CTRL_BITS = 4;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_PERIOD = 2'd1,
        SEL_SCALE  = 2'd2,
        SEL_COUNT  = 2'd3
    } reg_sel_e;

    // bit order is visible to software: [3] flag, [2] reload, [1] run, [0] power
    typedef struct packed {
        logic flag;
        logic reload;
        logic run;
        logic power;
    } ctrl_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  reg_sel_e      sel,
    input  logic [DW-1:0] wdata,
    input  logic          expire,
    output ctrl_t         ctrl_o,
    output logic [DW-1:0] period_o,
    output logic [DW-1:0] scale_o
);
    typedef struct packed {
        ctrl_t         ctrl;
        logic [DW-1:0] period;
        logic [DW-1:0] scale;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (sel)
                SEL_CTRL: begin
                    st_d.ctrl.power  = wdata[0];
                    st_d.ctrl.run    = wdata[1];
                    st_d.ctrl.reload = wdata[2];
                    st_d.ctrl.flag   = wdata[3] & st_q.ctrl.flag;
                end
                SEL_PERIOD: st_d.period = wdata;
                SEL_SCALE:  st_d.scale  = wdata;
                default: ;
            endcase
        end
        if (expire) st_d.ctrl.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o   = st_q.ctrl;
    assign period_o = st_q.period;
    assign scale_o  = st_q.scale;

    assert_flag_on_expire_R5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> st_q.ctrl.flag);

    assert_period_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel == SEL_PERIOD) |=> $stable(st_q.period));
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic [DW-1:0] scale,
    output logic          tick
);
    typedef struct packed {
        logic [DW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    // magnitude compare: a prescale lowered mid-run still yields a tick
    assign tick = active && (st_q.cnt >= scale);

    always_comb begin
        st_d = st_q;
        if (!active || tick) st_d.cnt = '0;
        else                 st_d.cnt = st_q.cnt + DW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_phase_cleared_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> st_q.cnt == '0);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          tick,
    input  logic          reload,
    input  logic [DW-1:0] period,
    input  logic          load_en,
    input  logic [DW-1:0] load_val,
    output logic [DW-1:0] count_o,
    output logic          expire_o,
    output logic          irq_o
);
    typedef struct packed {
        logic [DW-1:0] count;
        logic          act_prev;
        logic          irq;
    } st_t;

    st_t  st_d, st_q;
    logic start;
    logic hit;

    always_comb begin
        st_d          = st_q;
        st_d.act_prev = active;
        start         = active && !st_q.act_prev;
        hit           = (start && st_q.count == '0) || (tick && st_q.count == DW'(1));
        expire_o      = !load_en && hit;
        if (load_en)                        st_d.count = load_val;
        else if (expire_o)                  st_d.count = reload ? period : '0;
        else if (tick && st_q.count != '0)  st_d.count = st_q.count - DW'(1);
        st_d.irq = expire_o;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;
    assign irq_o   = st_q.irq;

    assert_frozen_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !load_en) |=> $stable(st_q.count));

    assert_no_rearm_oneshot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.count == '0 && !reload && !start && !load_en) |=> !st_q.irq);

    assert_reload_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && reload) |=> st_q.count == $past(period));

    assert_never_counts_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !expire_o) |=> st_q.count <= $past(st_q.count));

    assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (st_q.count == $past(load_val) && !st_q.irq));
endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import tmr_pkg::*;
#(
    parameter int DW     = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] SEL_MASK = ADDR_W'(4'hC);

    ctrl_t         ctrl_w;
    logic [DW-1:0] period_w, scale_w, count_w;
    logic          addr_ok, active, tick, expire;
    reg_sel_e      sel;

    assign addr_ok = (bus_addr & ~SEL_MASK) == '0;
    assign sel     = reg_sel_e'(bus_addr[3:2]);
    assign active  = ctrl_w.power && ctrl_w.run;

    tmr_regs #(.DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr && addr_ok),
        .sel      (sel),
        .wdata    (bus_wdata),
        .expire   (expire),
        .ctrl_o   (ctrl_w),
        .period_o (period_w),
        .scale_o  (scale_w)
    );

    tmr_prescaler #(.DW(DW)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .scale  (scale_w),
        .tick   (tick)
    );

    tmr_counter #(.DW(DW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .tick     (tick),
        .reload   (ctrl_w.reload),
        .period   (period_w),
        .load_en  (bus_wr && addr_ok && sel == SEL_COUNT),
        .load_val (bus_wdata),
        .count_o  (count_w),
        .expire_o (expire),
        .irq_o    (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (addr_ok) begin
            unique case (sel)
                SEL_CTRL:   bus_rdata = DW'(ctrl_w);
                SEL_PERIOD: bus_rdata = period_w;
                SEL_SCALE:  bus_rdata = scale_w;
                SEL_COUNT:  bus_rdata = count_w;
                default:    bus_rdata = '0;
            endcase
        end
    end

    assert_irq_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctrl_w.flag);

    assert_idle_no_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !$past(active)) |=> !irq);
endmodule

// File: tb/sim_interval_timer.sv
module sim_interval_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          checks = 0;
    int          fails = 0;

    always #2 clk = ~clk;

    interval_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // leaves the bench 1 ns after the edge E that took the write
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // edges counted after the last write edge until irq is seen
    task automatic wait_irq(output int k);
        k = 0;
        forever begin
            @(negedge clk);
            if (irq || k > 600) break;
            @(posedge clk);
            k++;
        end
    endtask

    task automatic wait_next(output int k);
        k = 0;
        do begin
            @(posedge clk); k++;
            @(negedge clk);
        end while (!irq && k < 600);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired, all requirements");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int k;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 16; a += 4) begin
            rd(4'(a), v); check("R1 reset read", v, 0);
        end
        check("R1 irq low", 32'(irq), 0);

        // R2 readback and decode
        wr(4'h4, 32'hA5A5_5A5A); rd(4'h4, v); check("R2 period", v, 32'hA5A5_5A5A);
        wr(4'h8, 32'h0000_1234); rd(4'h8, v); check("R2 prescale", v, 32'h1234);
        wr(4'hC, 32'h8000_0001); rd(4'hC, v); check("R2 count", v, 32'h8000_0001);
        wr(4'h0, 32'hFFFF_FFF0); rd(4'h0, v); check("R2 ctrl upper zero", v, 0);
        wr(4'h6, 32'h1111_1111); rd(4'h4, v); check("R2 misaligned write ignored", v, 32'hA5A5_5A5A);
        rd(4'h6, v); check("R2 misaligned read zero", v, 0);

        // R8 enable with zero count
        wr(4'h8, 0); wr(4'hC, 0);
        wr(4'h0, 3); wait_irq(k); check("R8 immediate irq edge", 32'(k), 1);
        rd(4'h0, v); check("R5 ctrl after one-shot", v, 32'hB);
        for (int r = 0; r < 2; r++) begin
            wr(4'h0, 0); wr(4'h0, 1); wr(4'h0, 3);
            wait_irq(k); check("R8 re-enable irq", 32'(k), 1);
        end
        wr(4'h0, 32'hB); rd(4'h0, v); check("R5 writing flag 1 keeps it", v, 32'hB);
        wr(4'h0, 3); rd(4'h0, v); check("R5 flag cleared by write", v, 3);
        wr(4'h0, 32'hB); rd(4'h0, v); check("R5 writing 1 never sets", v, 3);

        // R10 power hold
        wr(4'h0, 0); wr(4'h8, 0); wr(4'h4, 32'h77); wr(4'hC, 100);
        wr(4'h0, 3);
        repeat (9) @(negedge clk);
        wr(4'h0, 2);
        rd(4'hC, v); check("R10 frozen count", v, 90);
        repeat (5) @(negedge clk);
        rd(4'hC, v); check("R10 count stays frozen", v, 90);
        rd(4'h4, v); check("R10 period kept", v, 32'h77);
        wr(4'h0, 3); wait_irq(k); check("R10 resume from held count", 32'(k), 90);

        // R9 count write while running
        wr(4'h0, 0); wr(4'hC, 50); wr(4'h0, 3);
        repeat (3) @(negedge clk);
        wr(4'hC, 4); wait_irq(k); check("R9 running reload of count", 32'(k), 4);

        // sweep over count, prescale and mode: R3 R4 R5 R6 R7
        for (int md = 0; md < 2; md++)
            for (int p = 0; p < 4; p++)
                for (int n = 1; n <= 5; n++) begin
                    int pd;
                    logic seen;
                    pd = n + 2;
                    wr(4'h0, 0); wr(4'h4, 32'(pd)); wr(4'h8, 32'(p)); wr(4'hC, 32'(n));
                    wr(4'h0, md ? 32'h7 : 32'h3);
                    bus_addr = 4'hC;
                    wait_irq(k);
                    check("R4 R3 first expiry edge", 32'(k), 32'(n * (p + 1)));
                    check(md ? "R7 reloaded on expiry" : "R6 parked at zero",
                          bus_rdata, md ? 32'(pd) : 0);
                    if (md) begin
                        wait_next(k);
                        check("R7 reload interval", 32'(k), 32'(pd * (p + 1)));
                        rd(4'h0, v); check("R5 ctrl reload mode", v, 32'hF);
                    end else begin
                        seen = 1'b0;
                        for (int c = 0; c < 40; c++) begin
                            @(negedge clk);
                            if (irq) seen = 1'b1;
                        end
                        check("R6 no further irq", 32'(seen), 0);
                        rd(4'hC, v); check("R6 count holds zero", v, 0);
                        rd(4'h0, v); check("R5 ctrl one-shot mode", v, 32'hB);
                    end
                end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule